// File: doc/BRIEF.md
# Grouped Interrupt Collector With Summary Flags

This block gathers interrupt events from four functional groups: a hardware group, a bus-controller group, a bus-monitor group and a remote-terminal group. Each group owns three 16-bit registers. The first is an arm mask that decides which events are heeded. The second holds sticky flags that latch armed events. The third is an alert mask that decides which latched flags drive the shared interrupt line. Bit n of all three registers of a group refers to the same event source.

A host reaches the registers through a simple word-addressed read/write port. Reading a flag register returns its content and clears it. Flags whose alert bit is clear never raise the line; the host finds them by polling. The hardware group's flag register also carries three summary bits. These let one read show which of the other three groups has anything latched. The host reads that register first after an interrupt, then reads only the groups it points to.

Top module: `intr_group_hub`

## Requirements
- R1: After reset every arm mask, flag register and alert mask is zero, `irq` is low and `reg_rdata` is zero.
- R2: `reg_addr[3:2]` selects the group (0 hardware, 1 bus controller, 2 bus monitor, 3 remote terminal) and `reg_addr[1:0]` selects the register (0 arm mask, 1 flags, 2 alert mask, 3 unused and reads as zero). A write to an arm or alert mask stores `reg_wdata`. Read data appears on `reg_rdata` the cycle after `reg_rd` is sampled and holds until the next read.
- R3: An event bit sets its flag only if the matching arm bit was already 1 before the edge on which the event is sampled. An event that arrives while the arm bit is 0, including in the same cycle as the write that sets it, is lost and is not recognised later.
- R4: A flag stays set until its register is read; writes to a flag register have no effect.
- R5: Reading a flag register returns its value and clears exactly those bits. An event sampled in the same cycle as that read is kept and shows on the next read.
- R6: `irq` is a registered active-high level. It is high in exactly the cycles in which some group holds a flag whose alert bit is set, and it changes on the same edge as the flags and alert masks it depends on.
- R7: A flag whose alert bit is 0 does not raise `irq`. Setting the alert bit later raises `irq` while the flag is still held.
- R8: In the hardware flag register, bit 0 is set when any bus-controller flag is set, bit 1 for the bus-monitor group and bit 2 for the remote-terminal group. Reading the hardware flag register clears none of the other groups.
- R9: The hardware group uses only bits 15 to 3 for its own events. Bits 2 to 0 of its arm and alert masks read as zero, and `ev_hw[2:0]` is ignored.
- R10: One `irq` line serves all four groups. It stays high until the last alert-enabled flag in any group has been cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 4 | Register word address: group and register select |
| reg_wr | input | 1 | Write strobe for the arm and alert masks |
| reg_rd | input | 1 | Read strobe; a flag-register read also clears it |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| ev_hw | input | 16 | Hardware group event pulses (bits 15..3 used) |
| ev_bc | input | 16 | Bus-controller group event pulses |
| ev_mt | input | 16 | Bus-monitor group event pulses |
| ev_rt | input | 16 | Remote-terminal group event pulses |
| irq | output | 1 | Shared interrupt level to the host |

## Verification
Event vectors wider than the arm mask show that only armed bits latch. An event that lands in the same cycle as the write that arms its bit separates "armed before" from "armed at" the edge. A read that coincides with new events on both a returned bit and an unreturned bit shows that the clear keeps fresh arrivals. Alert-masked and unmasked flags in several groups, cleared one group at a time, show the shared line staying high until the last alerting flag is gone, and polled-only flags leaving it low. Reading the hardware flag register twice with three groups loaded shows that the summary bits track the other groups without clearing them.

// File: rtl/intr_pkg.sv
package intr_pkg;
    parameter int DATA_W = 16;
    parameter int NGRP   = 4;
    parameter int SUMM_W = NGRP - 1;
    parameter int GRP_W  = $clog2(NGRP);
    parameter int SEL_W  = 2;
    parameter int ADDR_W = GRP_W + SEL_W;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [NGRP-1:0][DATA_W-1:0] grp_vec_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_ARM   = 2'd0,
        SEL_FLAG  = 2'd1,
        SEL_ALERT = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        data_t arm;
        data_t flag;
        data_t alert;
    } grp_state_t;

    typedef struct packed {
        logic  irq;
        data_t rdata;
    } hub_state_t;

    // Bits a group really stores: the hardware group gives its low bits to the summary.
    parameter data_t HW_LIVE  = {{(DATA_W-SUMM_W){1'b1}}, {SUMM_W{1'b0}}};
    parameter data_t ALL_LIVE = '1;
endpackage

// File: rtl/intr_group.sv
module intr_group
    import intr_pkg::*;
#(
    parameter data_t LIVE = ALL_LIVE
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  arm_wr,
    input  logic  alert_wr,
    input  logic  flag_rd,
    input  data_t wdata,
    input  data_t ev,
    output data_t arm_o,
    output data_t flag_o,
    output data_t alert_o,
    output logic  irq_nxt_o
);
    grp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (arm_wr) begin
            st_d.arm = wdata & LIVE;
        end
        if (alert_wr) begin
            st_d.alert = wdata & LIVE;
        end
        // Events are gated by the arm mask held before this edge; a read
        // clears only the bits it returned, fresh events are merged after.
        st_d.flag = (flag_rd ? '0 : st_q.flag) | (ev & st_q.arm & LIVE);
        irq_nxt_o = |(st_d.flag & st_d.alert);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign arm_o   = st_q.arm;
    assign flag_o  = st_q.flag;
    assign alert_o = st_q.alert;
endmodule

// File: rtl/intr_decode.sv
module intr_decode
    import intr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic [NGRP-1:0]   arm_wr,
    output logic [NGRP-1:0]   alert_wr,
    output logic [NGRP-1:0]   flag_rd,
    output logic [GRP_W-1:0]  grp,
    output reg_sel_e          sel
);
    always_comb begin
        grp      = addr[ADDR_W-1 -: GRP_W];
        sel      = reg_sel_e'(addr[SEL_W-1:0]);
        arm_wr   = '0;
        alert_wr = '0;
        flag_rd  = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (grp == GRP_W'(g)) begin
                arm_wr[g]   = wr && (sel == SEL_ARM);
                alert_wr[g] = wr && (sel == SEL_ALERT);
                flag_rd[g]  = rd && (sel == SEL_FLAG);
            end
        end
    end
endmodule

// File: rtl/intr_rd_mux.sv
module intr_rd_mux
    import intr_pkg::*;
(
    input  logic [GRP_W-1:0] grp,
    input  reg_sel_e         sel,
    input  grp_vec_t         arm_a,
    input  grp_vec_t         flag_a,
    input  grp_vec_t         alert_a,
    output data_t            rd_data
);
    logic [SUMM_W-1:0] summ;

    genvar k;
    generate
        for (k = 1; k < NGRP; k++) begin : g_summ
            assign summ[k-1] = |flag_a[k];
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        case (sel)
            SEL_ARM:   rd_data = arm_a[grp];
            SEL_ALERT: rd_data = alert_a[grp];
            SEL_FLAG: begin
                if (grp == '0) begin
                    rd_data = flag_a[0] | DATA_W'(summ);
                end else begin
                    rd_data = flag_a[grp];
                end
            end
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/intr_group_hub.sv
module intr_group_hub
    import intr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] ev_hw,
    input  logic [DATA_W-1:0] ev_bc,
    input  logic [DATA_W-1:0] ev_mt,
    input  logic [DATA_W-1:0] ev_rt,
    output logic              irq
);
    grp_vec_t         ev_a;
    grp_vec_t         arm_a;
    grp_vec_t         flag_a;
    grp_vec_t         alert_a;
    logic [NGRP-1:0]  arm_wr;
    logic [NGRP-1:0]  alert_wr;
    logic [NGRP-1:0]  flag_rd;
    logic [NGRP-1:0]  irq_nxt;
    logic [GRP_W-1:0] grp;
    reg_sel_e         sel;
    data_t            mux_data;
    hub_state_t       st_d, st_q;

    assign ev_a[0] = ev_hw;
    assign ev_a[1] = ev_bc;
    assign ev_a[2] = ev_mt;
    assign ev_a[3] = ev_rt;

    intr_decode u_dec (
        .addr     (reg_addr),
        .wr       (reg_wr),
        .rd       (reg_rd),
        .arm_wr   (arm_wr),
        .alert_wr (alert_wr),
        .flag_rd  (flag_rd),
        .grp      (grp),
        .sel      (sel)
    );

    genvar g;
    generate
        for (g = 0; g < NGRP; g++) begin : g_grp
            localparam data_t LIVE = (g == 0) ? HW_LIVE : ALL_LIVE;
            intr_group #(.LIVE(LIVE)) u_grp (
                .clk       (clk),
                .rst_n     (rst_n),
                .arm_wr    (arm_wr[g]),
                .alert_wr  (alert_wr[g]),
                .flag_rd   (flag_rd[g]),
                .wdata     (reg_wdata),
                .ev        (ev_a[g]),
                .arm_o     (arm_a[g]),
                .flag_o    (flag_a[g]),
                .alert_o   (alert_a[g]),
                .irq_nxt_o (irq_nxt[g])
            );
        end
    endgenerate

    intr_rd_mux u_mux (
        .grp     (grp),
        .sel     (sel),
        .arm_a   (arm_a),
        .flag_a  (flag_a),
        .alert_a (alert_a),
        .rd_data (mux_data)
    );

    always_comb begin
        st_d       = st_q;
        st_d.irq   = |irq_nxt;
        if (reg_rd) begin
            st_d.rdata = mux_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = st_q.rdata;
    assign irq       = st_q.irq;
endmodule

// File: rtl/intr_group_hub_chk.sv
module intr_group_hub_chk
    import intr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq,
    input grp_vec_t          ev_a,
    input grp_vec_t          arm_a,
    input grp_vec_t          flag_a,
    input grp_vec_t          alert_a
);
    logic any_alert;
    always_comb begin
        any_alert = 1'b0;
        for (int g = 0; g < NGRP; g++) begin
            any_alert = any_alert | (|(flag_a[g] & alert_a[g]));
        end
    end

    localparam logic [ADDR_W-1:0] HW_FLAG_A = ADDR_W'(SEL_FLAG);

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq == any_alert); // R6

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata)); // R2

    AST_SUMM_BC: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == HW_FLAG_A) |=> (reg_rdata[0] == |$past(flag_a[1]))); // R8
    AST_SUMM_MT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == HW_FLAG_A) |=> (reg_rdata[1] == |$past(flag_a[2]))); // R8
    AST_SUMM_RT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == HW_FLAG_A) |=> (reg_rdata[2] == |$past(flag_a[3]))); // R8

    genvar g;
    generate
        for (g = 0; g < NGRP; g++) begin : g_chk
            localparam logic [ADDR_W-1:0] FA = ADDR_W'(g * (1 << SEL_W) + int'(SEL_FLAG));

            AST_FLAG_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_a[g] & ~$past(flag_a[g]) & ~$past(arm_a[g])) == '0); // R3

            AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                !(reg_rd && reg_addr == FA) |=>
                    ((flag_a[g] & $past(flag_a[g])) == $past(flag_a[g]))); // R4

            AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_rd && reg_addr == FA) |=>
                    ((flag_a[g] & ~$past(ev_a[g] & arm_a[g])) == '0)); // R5
        end
    endgenerate
endmodule

bind intr_group_hub intr_group_hub_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .ev_a      (ev_a),
    .arm_a     (arm_a),
    .flag_a    (flag_a),
    .alert_a   (alert_a)
);

// File: tb/sim_intr_group_hub.sv
`timescale 1ns/1ps
module sim_intr_group_hub;
    localparam logic [3:0] HW_ARM = 4'h0, HW_FLG = 4'h1, HW_ALR = 4'h2;
    localparam logic [3:0] BC_ARM = 4'h4, BC_FLG = 4'h5, BC_ALR = 4'h6;
    localparam logic [3:0] MT_ARM = 4'h8, MT_FLG = 4'h9, MT_ALR = 4'hA;
    localparam logic [3:0] RT_ARM = 4'hC, RT_FLG = 4'hD, RT_ALR = 4'hE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] ev_hw = '0, ev_bc = '0, ev_mt = '0, ev_rt = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic cmp_now = 1'b0;
    string       tq[$];
    logic [15:0] eq[$];

    always #10 clk = ~clk;

    intr_group_hub u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ev_hw     (ev_hw),
        .ev_bc     (ev_bc),
        .ev_mt     (ev_mt),
        .ev_rt     (ev_rt),
        .irq       (irq)
    );

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
            finish_run();
        end
    end

    // Monitor: read data is due one edge after the strobe.
    always @(posedge clk) cmp_now <= reg_rd;
    always @(negedge clk) begin
        if (cmp_now) begin
            string       tg;
            logic [15:0] ex;
            tg = tq.pop_front();
            ex = eq.pop_front();
            total = total + 1;
            if (reg_rdata !== ex) begin
                bad = bad + 1;
                $display("FAIL %s: rdata actual=%h expected=%h", tg, reg_rdata, ex);
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one cycle per call, started and ended at a falling edge.
    task automatic cyc(input logic w, input logic r, input logic [3:0] a, input logic [15:0] wd,
                       input logic [15:0] eh, input logic [15:0] eb, input logic [15:0] em,
                       input logic [15:0] er, input logic [15:0] exp, input string tag);
        reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = wd;
        ev_hw = eh; ev_bc = eb; ev_mt = em; ev_rt = er;
        if (r) begin
            tq.push_back(tag);
            eq.push_back(exp);
        end
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
        ev_hw = '0; ev_bc = '0; ev_mt = '0; ev_rt = '0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        cyc(1'b1, 1'b0, a, d, '0, '0, '0, '0, '0, "");
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
        cyc(1'b0, 1'b1, a, '0, '0, '0, '0, '0, exp, tag);
    endtask

    task automatic pulse(input logic [15:0] eh, input logic [15:0] eb,
                         input logic [15:0] em, input logic [15:0] er);
        cyc(1'b0, 1'b0, 4'h0, '0, eh, eb, em, er, '0, "");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", {15'd0, irq}, 16'h0000);
        chk("R1 rdata after reset", reg_rdata, 16'h0000);
        rd(BC_ARM, 16'h0000, "R1 arm mask zero");
        rd(HW_FLG, 16'h0000, "R1 flags zero");
        rd(RT_ALR, 16'h0000, "R1 alert mask zero");

        wr(HW_ARM, 16'hFFFF); wr(BC_ARM, 16'hFFFF); wr(MT_ARM, 16'h00F0);
        wr(RT_ARM, 16'hA5A5); wr(HW_ALR, 16'hFFFF); wr(BC_ALR, 16'h0001);
        rd(HW_ARM, 16'hFFF8, "R9 hw arm low bits");
        rd(RT_ARM, 16'hA5A5, "R2 rt arm readback");
        rd(HW_ALR, 16'hFFF8, "R9 hw alert low bits");
        rd(BC_ALR, 16'h0001, "R2 bc alert readback");
        rd(4'h3, 16'h0000, "R2 unused slot");

        // Armed subset only
        pulse('0, '0, 16'h0FF0, '0);
        chk("R7 mt flag without alert", {15'd0, irq}, 16'h0000);
        rd(MT_FLG, 16'h00F0, "R3 armed subset");
        rd(MT_FLG, 16'h0000, "R5 cleared by read");

        // Unarmed events are dropped and not recovered
        pulse('0, '0, '0, 16'h0002);
        wr(RT_ARM, 16'hFFFF);
        rd(RT_FLG, 16'h0000, "R3 dropped while unarmed");
        wr(RT_ARM, 16'h0000);
        cyc(1'b1, 1'b0, RT_ARM, 16'h0008, '0, '0, '0, 16'h0008, '0, "");
        rd(RT_FLG, 16'h0000, "R3 arm and event same cycle");
        pulse('0, '0, '0, 16'h0008);
        rd(RT_FLG, 16'h0008, "R3 armed event latched");

        // Sticky, write-proof flags
        pulse('0, 16'h0100, '0, '0);
        wr(BC_FLG, 16'h0000);
        wr(BC_FLG, 16'hFFFF);
        pulse('0, '0, '0, '0);
        pulse('0, '0, '0, '0);
        rd(BC_FLG, 16'h0100, "R4 sticky and write-proof");

        // Polled vs alerting, summary
        pulse('0, 16'h0002, '0, '0);
        chk("R7 polled-only flag", {15'd0, irq}, 16'h0000);
        rd(HW_FLG, 16'h0001, "R8 bc summary bit");
        rd(BC_FLG, 16'h0002, "R8 hw read left bc intact");
        pulse('0, 16'h0001, '0, '0);
        chk("R6 irq rises with flag", {15'd0, irq}, 16'h0001);
        rd(BC_FLG, 16'h0001, "R6 bc alerting flag");
        chk("R6 irq falls with clear", {15'd0, irq}, 16'h0000);

        pulse('0, '0, 16'h0010, '0);
        chk("R7 mt held, no alert", {15'd0, irq}, 16'h0000);
        wr(MT_ALR, 16'h0010);
        chk("R7 late alert raises irq", {15'd0, irq}, 16'h0001);
        wr(RT_ALR, 16'h0008);
        pulse('0, '0, '0, 16'h0008);
        rd(MT_FLG, 16'h0010, "R10 mt flag");
        chk("R10 irq held by rt", {15'd0, irq}, 16'h0001);
        rd(RT_FLG, 16'h0008, "R10 rt flag");
        chk("R10 irq low after last", {15'd0, irq}, 16'h0000);

        // Read coinciding with events
        pulse('0, 16'h0004, '0, '0);
        cyc(1'b0, 1'b1, BC_FLG, '0, '0, 16'h0044, '0, '0, 16'h0004, "R5 read with events");
        rd(BC_FLG, 16'h0044, "R5 events kept across read");

        // Hardware group own bits
        pulse(16'h8007, '0, '0, '0);
        chk("R9 hw alert irq", {15'd0, irq}, 16'h0001);
        rd(HW_FLG, 16'h8000, "R9 hw low events ignored");
        chk("R6 irq low after hw read", {15'd0, irq}, 16'h0000);
        rd(HW_FLG, 16'h0000, "R5 hw cleared");

        // All summaries together
        pulse('0, 16'h1000, 16'h0020, 16'h0008);
        rd(HW_FLG, 16'h0007, "R8 all summaries");
        rd(HW_FLG, 16'h0007, "R8 summaries not cleared");
        rd(BC_FLG, 16'h1000, "R8 bc content");
        rd(HW_FLG, 16'h0006, "R8 bc summary gone");
        rd(MT_FLG, 16'h0020, "R8 mt content");
        rd(RT_FLG, 16'h0008, "R8 rt content");
        rd(HW_FLG, 16'h0000, "R8 all summaries clear");
        chk("R10 irq idle", {15'd0, irq}, 16'h0000);

        repeat (2) @(negedge clk);
        if (tq.size() != 0) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL R2 reads outstanding: actual=%0d expected=0", tq.size());
        end
        finish_run();
    end
endmodule